// File: doc/BRIEF.md
# Flow-control pause frame detector

The block watches a received Ethernet frame as it passes byte by byte on a receive stream. Each byte carries qualifiers for first byte, last byte and receive error. The block decides whether the frame is a valid flow-control pause request. The destination address must equal either a programmable station address or the reserved control multicast address 01-80-C2-00-00-01. The type field must select MAC control and the opcode must select pause. The two bytes after the opcode are the pause duration, and the block captures them.

The verdict is formed only on the last byte, and it uses the frame-check-sequence flag supplied with that byte. On a valid frame the block pulses a strobe with the captured pause duration, pulses a statistics increment, and raises an interrupt pulse when the interrupt enable is set. These outputs do not depend on any duplex or transmit-pause setting. A downstream pause timer and a counter consume the outputs.

Top module: `pause_detect`

## Requirements
- R1: After synchronous reset, pause_strobe, pause_irq and stat_inc are low and pause_time is zero.
- R2: A frame whose bytes 0 to 5 (most significant byte first) equal station_addr is accepted, provided the other checks pass.
- R3: A frame whose bytes 0 to 5 equal 01 80 C2 00 00 01 is accepted, provided the other checks pass. A destination equal to neither address is rejected.
- R4: Bytes 12 and 13 must be 0x88 then 0x08, or the frame is rejected.
- R5: Bytes 14 and 15 must be 0x00 then 0x01, or the frame is rejected.
- R6: On acceptance, pause_time takes byte 16 as its high byte and byte 17 as its low byte. It keeps that value until the next accepted frame.
- R7: A frame of fewer than 18 bytes is rejected. Longer frames are judged on their first 18 bytes only.
- R8: A frame is rejected if rx_fcs_ok is low on its last byte, or if rx_err is high in any cycle from its first byte to its last byte, idle cycles included. The value of rx_fcs_ok on other bytes is ignored.
- R9: For an accepted frame, pause_strobe and stat_inc are high for exactly the one cycle after the last byte's clock edge.
- R10: pause_irq pulses together with pause_strobe when irq_en is high, and stays low when irq_en is low.
- R11: A first-byte flag that arrives inside an unfinished frame starts parsing afresh. Earlier bytes and errors are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_data holds a frame byte this cycle |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error seen this cycle |
| rx_fcs_ok | input | 1 | FCS good flag, sampled with the last byte |
| station_addr | input | 48 | Programmable station address |
| irq_en | input | 1 | Interrupt enable |
| pause_strobe | output | 1 | One-cycle pulse for an accepted pause frame |
| pause_time | output | 16 | Pause duration from the last accepted frame |
| pause_irq | output | 1 | Interrupt pulse for an accepted frame |
| stat_inc | output | 1 | Statistics increment pulse |

## Verification
The bench flips each of two bits in every destination byte against both addresses, and flips every bit of the type and opcode fields. A design that compared only part of a field, or in the wrong byte order, would accept a corrupted frame. Frame lengths sweep across the 18-byte limit, with the last field byte arriving on the final byte. A design that left out the current byte, or miscounted by one, would lose the pause time or accept a runt. A receive error is placed on every byte position and in an idle gap, and the FCS flag is inverted on non-final bytes, so a design that sampled errors or the FCS flag at the wrong time would be caught. A frame restarted by a second first-byte flag checks that stale state is cleared.

// File: rtl/pause_pkg.sv
package pause_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 48;
    localparam int FIELD_W   = 16;
    localparam int HDR_BYTES = 18;
    localparam int CNT_W     = $clog2(HDR_BYTES + 1);
    localparam int N_ADDR    = 2;

    localparam logic [ADDR_W-1:0]  CTRL_MCAST    = 48'h0180C2000001;
    localparam logic [FIELD_W-1:0] TYPE_MAC_CTRL = 16'h8808;
    localparam logic [FIELD_W-1:0] OPC_PAUSE     = 16'h0001;

    typedef struct packed {
        logic [ADDR_W-1:0]  dst;
        logic [FIELD_W-1:0] etype;
        logic [FIELD_W-1:0] opcode;
        logic [FIELD_W-1:0] quanta;
    } hdr_t;

    typedef struct packed {
        logic               hit;
        logic [FIELD_W-1:0] quanta;
    } verdict_t;

    // place one received byte into the header record, network order
    function automatic hdr_t hdr_insert(input hdr_t h, input logic [CNT_W-1:0] idx,
                                        input logic [BYTE_W-1:0] b);
        hdr_t r;
        int   k;
        r = h;
        k = int'(idx);
        if (k < 6)
            r.dst[(5 - k) * BYTE_W +: BYTE_W] = b;
        else if (k == 12 || k == 13)
            r.etype[(13 - k) * BYTE_W +: BYTE_W] = b;
        else if (k == 14 || k == 15)
            r.opcode[(15 - k) * BYTE_W +: BYTE_W] = b;
        else if (k == 16 || k == 17)
            r.quanta[(17 - k) * BYTE_W +: BYTE_W] = b;
        return r;
    endfunction
endpackage

// File: rtl/pause_hdr_capture.sv
module pause_hdr_capture
    import pause_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_err,
    output hdr_t              hdr_now,
    output logic              long_enough,
    output logic              err_now,
    output logic              frame_end
);
    logic             in_frame;
    logic [CNT_W-1:0] cnt;
    logic             err_q;
    hdr_t             hdr_q;

    logic             start;
    logic             active;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        start       = rx_valid && rx_sof;
        active      = start || (in_frame && rx_valid);
        idx         = start ? '0 : cnt;
        hdr_now     = active ? hdr_insert(start ? '0 : hdr_q, idx, rx_data) : hdr_q;
        long_enough = (idx >= CNT_W'(HDR_BYTES - 1));
        err_now     = (start ? 1'b0 : err_q) || rx_err;
        frame_end   = active && rx_eof;
        cnt_next    = (idx >= CNT_W'(HDR_BYTES)) ? CNT_W'(HDR_BYTES) : idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            cnt      <= '0;
            err_q    <= 1'b0;
            hdr_q    <= '0;
        end else if (active) begin
            hdr_q    <= hdr_now;
            cnt      <= cnt_next;
            err_q    <= err_now;
            in_frame <= !rx_eof;
        end else if (in_frame && rx_err) begin
            err_q    <= 1'b1;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(HDR_BYTES));

    // R11
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && !rx_eof) |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/pause_match.sv
module pause_match
    import pause_pkg::*;
(
    input  hdr_t                    hdr,
    input  logic [N_ADDR*ADDR_W-1:0] addr_list,
    input  logic                    long_enough,
    input  logic                    err_now,
    input  logic                    fcs_ok,
    input  logic                    frame_end,
    output verdict_t                verdict
);
    logic [N_ADDR-1:0] addr_hit;

    genvar g;
    generate
        for (g = 0; g < N_ADDR; g++) begin : g_addr
            assign addr_hit[g] = (hdr.dst == addr_list[g*ADDR_W +: ADDR_W]);
        end
    endgenerate

    always_comb begin
        verdict.hit    = frame_end && long_enough && !err_now && fcs_ok &&
                         (|addr_hit) &&
                         (hdr.etype == TYPE_MAC_CTRL) &&
                         (hdr.opcode == OPC_PAUSE);
        verdict.quanta = hdr.quanta;
    end
endmodule

// File: rtl/pause_report.sv
module pause_report
    import pause_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  verdict_t           verdict,
    input  logic               irq_en,
    output logic               pause_strobe,
    output logic [FIELD_W-1:0] pause_time,
    output logic               pause_irq,
    output logic               stat_inc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pause_strobe <= 1'b0;
            pause_irq    <= 1'b0;
            stat_inc     <= 1'b0;
            pause_time   <= '0;
        end else begin
            pause_strobe <= verdict.hit;
            stat_inc     <= verdict.hit;
            pause_irq    <= verdict.hit && irq_en;
            if (verdict.hit)
                pause_time <= verdict.quanta;
        end
    end

    // R6
    time_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pause_strobe |-> $stable(pause_time));

    // R10
    irq_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pause_irq |-> pause_strobe);

    // R9
    stat_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        stat_inc == pause_strobe);
endmodule

// File: rtl/pause_detect.sv
module pause_detect
    import pause_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic [7:0]         rx_data,
    input  logic               rx_err,
    input  logic               rx_fcs_ok,
    input  logic [47:0]        station_addr,
    input  logic               irq_en,
    output logic               pause_strobe,
    output logic [15:0]        pause_time,
    output logic               pause_irq,
    output logic               stat_inc
);
    hdr_t     hdr_now;
    logic     long_enough;
    logic     err_now;
    logic     frame_end;
    verdict_t verdict;

    pause_hdr_capture u_capture (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .rx_data     (rx_data),
        .rx_err      (rx_err),
        .hdr_now     (hdr_now),
        .long_enough (long_enough),
        .err_now     (err_now),
        .frame_end   (frame_end)
    );

    pause_match u_match (
        .hdr         (hdr_now),
        .addr_list   ({CTRL_MCAST, station_addr}),
        .long_enough (long_enough),
        .err_now     (err_now),
        .fcs_ok      (rx_fcs_ok),
        .frame_end   (frame_end),
        .verdict     (verdict)
    );

    pause_report u_report (
        .clk          (clk),
        .rst          (rst),
        .verdict      (verdict),
        .irq_en       (irq_en),
        .pause_strobe (pause_strobe),
        .pause_time   (pause_time),
        .pause_irq    (pause_irq),
        .stat_inc     (stat_inc)
    );

    // R8
    strobe_needs_good_end_chk: assert property (@(posedge clk) disable iff (rst)
        pause_strobe |-> $past(rx_valid && rx_eof && rx_fcs_ok && !rx_err));
endmodule

// File: tb/test_pause_detect.sv
`timescale 1ns/1ps
module test_pause_detect;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_sof, rx_eof, rx_err, rx_fcs_ok, irq_en;
    logic [7:0]  rx_data;
    logic [47:0] station_addr;
    logic        pause_strobe, pause_irq, stat_inc;
    logic [15:0] pause_time;

    localparam logic [47:0] STA = 48'h021122334455;
    localparam logic [47:0] MC  = 48'h0180C2000001;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0]  frm [0:23];
    logic [15:0] last_time = 16'h0;

    always #4 clk = ~clk;

    pause_detect i_pause_detect (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_err(rx_err), .rx_fcs_ok(rx_fcs_ok),
        .station_addr(station_addr), .irq_en(irq_en),
        .pause_strobe(pause_strobe), .pause_time(pause_time),
        .pause_irq(pause_irq), .stat_inc(stat_inc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [47:0] da, input logic [15:0] ty,
                         input logic [15:0] op, input logic [15:0] pt);
        for (int i = 0; i < 24; i++) frm[i] = 8'(8'hA0 + i);
        for (int i = 0; i < 6; i++) frm[i] = da[(5-i)*8 +: 8];
        frm[12] = ty[15:8]; frm[13] = ty[7:0];
        frm[14] = op[15:8]; frm[15] = op[7:0];
        frm[16] = pt[15:8]; frm[17] = pt[7:0];
    endtask

    task automatic idle();
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_data = 8'h00; rx_fcs_ok = 0;
    endtask

    // send frm[0..len-1]; err_idx marks a byte with rx_err, gap_idx inserts an idle cycle
    task automatic send(input int len, input bit good, input int err_idx,
                        input int gap_idx, input bit gap_err, input bit en,
                        input string tag);
        logic [47:0] da;
        bit ok;
        irq_en = en;
        for (int i = 0; i < len; i++) begin
            if (i == gap_idx) begin
                @(negedge clk);
                idle();
                rx_err = gap_err;
            end
            @(negedge clk);
            rx_valid  = 1;
            rx_sof    = (i == 0);
            rx_eof    = (i == len - 1);
            rx_data   = frm[i];
            rx_err    = (i == err_idx);
            rx_fcs_ok = (i == len - 1) ? good : !good;
        end
        @(negedge clk);
        idle();
        for (int i = 0; i < 6; i++) da[(5-i)*8 +: 8] = frm[i];
        ok = (len >= 18) && good && !(err_idx >= 0 && err_idx < len) &&
             !(gap_err && gap_idx > 0 && gap_idx < len) &&
             (da == STA || da == MC) &&
             frm[12] == 8'h88 && frm[13] == 8'h08 &&
             frm[14] == 8'h00 && frm[15] == 8'h01;
        if (ok) last_time = {frm[16], frm[17]};
        chk(pause_strobe == ok, {tag, " R9 strobe"}, 32'(pause_strobe), 32'(ok));
        chk(stat_inc == ok, {tag, " R9 stat"}, 32'(stat_inc), 32'(ok));
        chk(pause_irq == (ok && en), {tag, " R10 irq"}, 32'(pause_irq), 32'(ok && en));
        chk(pause_time == last_time, {tag, " R6 time"}, 32'(pause_time), 32'(last_time));
        @(negedge clk);
        chk(!pause_strobe && !stat_inc && !pause_irq, {tag, " R9 single pulse"},
            32'({pause_strobe, stat_inc, pause_irq}), 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        irq_en = 1;
        station_addr = STA;
        rst = 1;
        repeat (3) @(negedge clk);
        chk(!pause_strobe && !pause_irq && !stat_inc && pause_time == 0, "R1 reset",
            32'({pause_strobe, pause_irq, stat_inc}), 32'h0);
        rst = 0;
        @(negedge clk);

        // R2 and R3: both addresses, plus single-bit corruption of each byte
        for (int a = 0; a < 2; a++) begin
            build(a == 0 ? STA : MC, 16'h8808, 16'h0001, 16'(16'h1234 + a * 16'h1111));
            send(18, 1, -1, -1, 0, 1, a == 0 ? "R2 station" : "R3 mcast");
            for (int p = 0; p < 6; p++)
                for (int b = 0; b < 8; b += 7) begin
                    build(a == 0 ? STA : MC, 16'h8808, 16'h0001, 16'(p * 16 + b + 16'h0100));
                    frm[p] = frm[p] ^ (8'h1 << b);
                    send(18, 1, -1, -1, 0, 1, "R3 address mismatch");
                end
        end
        // R4 and R5: flip each bit of type and opcode
        for (int b = 0; b < 16; b++) begin
            build(STA, 16'h8808 ^ (16'h1 << b), 16'h0001, 16'hBEEF);
            send(18, 1, -1, -1, 0, 1, "R4 type bit");
            build(MC, 16'h8808, 16'h0001 ^ (16'h1 << b), 16'hCAFE);
            send(18, 1, -1, -1, 0, 1, "R5 opcode bit");
        end
        // R7: length sweep across the limit
        for (int l = 1; l <= 22; l++) begin
            build(MC, 16'h8808, 16'h0001, 16'(16'h4000 + l));
            send(l, 1, -1, -1, 0, 1, "R7 length");
        end
        // R8: FCS bad, error on each byte, error in an idle gap
        build(STA, 16'h8808, 16'h0001, 16'h7777);
        send(20, 0, -1, -1, 0, 1, "R8 fcs bad");
        for (int e = 0; e < 20; e++) begin
            build(STA, 16'h8808, 16'h0001, 16'(16'h5000 + e));
            send(20, 1, e, -1, 0, 1, "R8 err position");
        end
        build(MC, 16'h8808, 16'h0001, 16'h6161);
        send(19, 1, -1, 9, 1, 1, "R8 err in gap");
        build(MC, 16'h8808, 16'h0001, 16'h6262);
        send(19, 1, -1, 9, 0, 1, "R8 clean gap");
        // R10: enable low
        build(STA, 16'h8808, 16'h0001, 16'hFFFF);
        send(18, 1, -1, -1, 0, 0, "R10 irq off");
        build(MC, 16'h8808, 16'h0001, 16'h0000);
        send(18, 1, -1, -1, 0, 1, "R6 zero time");
        // R11: an unfinished frame with an error, then a restart
        build(16'h0, 16'h0, 16'h0, 16'h0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = 0; rx_data = frm[i];
            rx_err = (i == 3); rx_fcs_ok = 0;
        end
        build(STA, 16'h8808, 16'h0001, 16'h2468);
        send(18, 1, -1, -1, 0, 1, "R11 restart");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule